// File: doc/BRIEF.md
# Multi-Channel UART Host Register Decoder

This block sits between a byte-wide host bus and an array of UART channels. It turns a bus address into register selects for one channel. Each channel owns a sixteen-byte window whose base is sixteen times the channel number. Offset zero of a window is the data port: a write there hands a byte to the transmitter, and a read there takes a byte from the receiver. Line status lives at another offset, so a data-port read returns the data byte alone and never its error flags. All other offsets are configuration registers, which the decoder forwards as a shared 4-bit offset and a shared write byte, together with per-channel strobes.

Addresses with the top bit set form a global window. Offset 0x00 of that window is a read-only identity byte. Its upper nibble is a family code and its lower nibble is the channel count, so eight channels give 0x28 and four channels give 0x24. Offset 0x01 is a read-only revision byte that starts at 0x01 and rises by one with each revision. Offset 0x02 is a fan-out control register whose bit 0, while set, copies any configuration write to every channel at once. The data port is never copied. Reads always come from the addressed channel alone.

Read data is held in a register and is valid in the cycle after the read strobe is sampled. The read path is a two-state machine. RP_IDLE drives zero on the read bus. RP_HOLD drives the byte captured at the last edge. The transition RP_IDLE→RP_HOLD happens on a sampled read strobe. RP_HOLD→RP_HOLD happens on back-to-back reads. RP_HOLD→RP_IDLE happens when no read is sampled. Reset enters RP_IDLE.

Top module: `ufe_bus_front`

## Requirements
- R1: An address whose bit 7 is 0 and whose bits 6:4 equal n, where n is below the channel count, selects channel n. A write there raises only ch_wr[n] (fan-out off), with ch_addr equal to address bits 3:0 and ch_wdata equal to the bus byte.
- R2: A write to offset 0 of a channel window raises the strobe of that channel only, whether fan-out is on or off.
- R3: A read raises at most one ch_rd bit, that of the addressed channel. The byte that channel presents for ch_addr becomes bus_rdata. Offset 0 reads that channel's receive byte.
- R4: A read of address 0x80 returns {family nibble 0x2, channel count}, which is 0x28 with eight channels.
- R5: A read of address 0x81 returns the revision parameter, 0x01 by default.
- R6: Address 0x82 is the fan-out control register. Bit 0 resets to 0 and is written from bus bit 0. Bits 7:1 always read 0, whatever was written.
- R7: While control bit 0 is 1, a write to offsets 1 to 15 of any channel window raises every channel's ch_wr, with the same offset and byte on all of them.
- R8: Addresses 0x80 to 0xFF, and channel windows at or above the channel count, raise no ch_wr or ch_rd. Reads there return 0x00, except at 0x80 to 0x82. Writes there change nothing.
- R9: bus_rdata is 0x00 after reset and in any cycle whose previous edge sampled no read. After a sampled read it carries the selected byte for one cycle.
- R10: Writes to 0x80 and 0x81 have no effect on their read values or on any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Host byte address |
| bus_wdata | input | 8 | Host write byte |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read byte |
| ch_addr | output | 4 | Register offset shared by all channels |
| ch_wdata | output | 8 | Write byte shared by all channels |
| ch_wr | output | 8 | Per-channel write strobes |
| ch_rd | output | 8 | Per-channel read strobes |
| ch_rdata | input | 64 | Per-channel read bytes, channel n in bits 8n+7:8n |

## Verification
Every configuration offset of every channel is written with a value derived from its channel and offset, then read back. A mis-steered strobe or a wrong offset therefore shows up as a value that belongs to another slot. Data-port writes and reads are swept per channel with fan-out off and on. The bench counts transmit bytes per channel, which separates the data port from the fan-out path. The whole unmapped and global range is then swept with writes and reads, while strobe counters confirm that no channel is selected. The control register is written with all-ones and alternating patterns to separate bit 0 from the reserved bits.

// File: rtl/ufe_pkg.sv
package ufe_pkg;

    typedef enum logic [2:0] {
        RG_CHAN,
        RG_ID,
        RG_REV,
        RG_CTL,
        RG_NONE
    } region_e;

    typedef enum logic {
        RP_IDLE,
        RP_HOLD
    } rd_state_e;

    localparam int GLB_ID_OFF  = 0;
    localparam int GLB_REV_OFF = 1;
    localparam int GLB_CTL_OFF = 2;

endpackage

// File: rtl/ufe_addr_decode.sv
module ufe_addr_decode
    import ufe_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 4,
    localparam int SEL_W = ADDR_W - 1 - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              fan_en,
    output region_e           region,
    output logic [SEL_W-1:0]  ch_idx,
    output logic [NUM_CH-1:0] ch_wr,
    output logic [NUM_CH-1:0] ch_rd,
    output logic              ctl_wr
);

    localparam logic [SEL_W:0] NCH_L = (SEL_W + 1)'(NUM_CH);

    logic              glb_win;
    logic [SEL_W-1:0]  field;
    logic [OFF_W-1:0]  off;
    logic [ADDR_W-2:0] glb_off;
    logic              chan_ok;
    logic              fan_hit;

    always_comb begin
        glb_win = addr[ADDR_W-1];
        field   = addr[ADDR_W-2:OFF_W];
        off     = addr[OFF_W-1:0];
        glb_off = addr[ADDR_W-2:0];
        chan_ok = !glb_win && ({1'b0, field} < NCH_L);
        fan_hit = chan_ok && fan_en && (off != '0);
        ch_idx  = field;
    end

    always_comb begin
        region = RG_NONE;
        if (chan_ok) begin
            region = RG_CHAN;
        end else if (glb_win) begin
            if (glb_off == (ADDR_W - 1)'(GLB_ID_OFF))       region = RG_ID;
            else if (glb_off == (ADDR_W - 1)'(GLB_REV_OFF)) region = RG_REV;
            else if (glb_off == (ADDR_W - 1)'(GLB_CTL_OFF)) region = RG_CTL;
        end
    end

    assign ctl_wr = wr && (region == RG_CTL);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        logic hit;
        assign hit      = chan_ok && (field == SEL_W'(c));
        assign ch_rd[c] = rd && hit;
        assign ch_wr[c] = wr && (hit || fan_hit);
    end

endmodule

// File: rtl/ufe_glob_regs.sv
module ufe_glob_regs
    import ufe_pkg::*;
#(
    parameter int          NUM_CH = 8,
    parameter int          DATA_W = 8,
    parameter logic [3:0]  FAMILY = 4'h2,
    parameter logic [7:0]  REV_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_bit,
    input  region_e           region,
    output logic              fan_en,
    output logic [DATA_W-1:0] glob_rdata
);

    localparam logic [7:0] ID_VAL = {FAMILY, 4'(NUM_CH)};

    logic fan_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fan_q <= 1'b0;
        end else if (ctl_wr) begin
            fan_q <= ctl_bit;
        end
    end

    assign fan_en = fan_q;

    always_comb begin
        unique case (region)
            RG_ID:   glob_rdata = DATA_W'(ID_VAL);
            RG_REV:  glob_rdata = DATA_W'(REV_ID);
            RG_CTL:  glob_rdata = DATA_W'(fan_q);
            default: glob_rdata = '0;
        endcase
    end

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(fan_q)); // R8

endmodule

// File: rtl/ufe_read_path.sv
module ufe_read_path
    import ufe_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd,
    input  region_e                  region,
    input  logic [SEL_W-1:0]         ch_idx,
    input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
    input  logic [DATA_W-1:0]        glob_rdata,
    output logic [DATA_W-1:0]        rdata
);

    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [DATA_W-1:0] sel_data;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        unique case (region)
            RG_CHAN:             sel_data = ch_rdata[ch_idx*DATA_W +: DATA_W];
            RG_ID, RG_REV, RG_CTL: sel_data = glob_rdata;
            default:             sel_data = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RP_IDLE: state_d = rd ? RP_HOLD : RP_IDLE;
            RP_HOLD: state_d = rd ? RP_HOLD : RP_IDLE;
            default: state_d = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (state_d == RP_HOLD) rdata_q <= sel_data;
        else                         rdata_q <= '0;
    end

    assign rdata = rdata_q;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RP_IDLE) |-> (rdata == '0)); // R9

endmodule

// File: rtl/ufe_bus_front.sv
module ufe_bus_front
    import ufe_pkg::*;
#(
    parameter int          NUM_CH = 8,
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 8,
    parameter int          OFF_W  = 4,
    parameter logic [3:0]  FAMILY = 4'h2,
    parameter logic [7:0]  REV_ID = 8'h01
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [OFF_W-1:0]         ch_addr,
    output logic [DATA_W-1:0]        ch_wdata,
    output logic [NUM_CH-1:0]        ch_wr,
    output logic [NUM_CH-1:0]        ch_rd,
    input  logic [NUM_CH*DATA_W-1:0] ch_rdata
);

    localparam int SEL_W = ADDR_W - 1 - OFF_W;
    localparam int CH_SPAN_TOP = NUM_CH << OFF_W;
    localparam logic [ADDR_W-1:0] ID_ADDR  = ADDR_W'((1 << (ADDR_W - 1)) + GLB_ID_OFF);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'((1 << (ADDR_W - 1)) + GLB_CTL_OFF);
    localparam logic [7:0] ID_VAL = {FAMILY, 4'(NUM_CH)};

    region_e           region;
    logic [SEL_W-1:0]  ch_idx;
    logic              ctl_wr;
    logic              fan_en;
    logic [DATA_W-1:0] glob_rdata;

    assign ch_addr  = bus_addr[OFF_W-1:0];
    assign ch_wdata = bus_wdata;

    ufe_addr_decode #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
    ) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .fan_en (fan_en),
        .region (region),
        .ch_idx (ch_idx),
        .ch_wr  (ch_wr),
        .ch_rd  (ch_rd),
        .ctl_wr (ctl_wr)
    );

    ufe_glob_regs #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .FAMILY(FAMILY), .REV_ID(REV_ID)
    ) u_glb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_bit    (bus_wdata[0]),
        .region     (region),
        .fan_en     (fan_en),
        .glob_rdata (glob_rdata)
    );

    ufe_read_path #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (bus_rd),
        .region     (region),
        .ch_idx     (ch_idx),
        .ch_rdata   (ch_rdata),
        .glob_rdata (glob_rdata),
        .rdata      (bus_rdata)
    );

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_rd)); // R3

    AST_DATA_PORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[OFF_W-1:0] == '0) |-> ($countones(ch_wr) <= 1)); // R2

    AST_FANOUT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && fan_en && (int'(bus_addr) < CH_SPAN_TOP) && bus_addr[OFF_W-1:0] != '0)
        |-> (&ch_wr)); // R7

    AST_GLOBAL_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[ADDR_W-1] |-> (ch_wr == '0 && ch_rd == '0)); // R8

    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R9

    AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ID_ADDR) |=> (bus_rdata == DATA_W'(ID_VAL))); // R4

    AST_CTL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CTL_ADDR) |=> (bus_rdata[DATA_W-1:1] == '0)); // R6

endmodule

// File: tb/ufe_bus_front_tb.sv
`timescale 1ns/1ps
module ufe_bus_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [3:0]  ch_addr;
    logic [7:0]  ch_wdata;
    logic [7:0]  ch_wr;
    logic [7:0]  ch_rd;
    logic [63:0] ch_rdata;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem [8][16];
    logic [7:0] tx_last [8];
    int         tx_cnt [8];
    int         wr_total;
    int         rd_total;

    always #2.5 clk = ~clk;

    ufe_bus_front dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ch_addr(ch_addr), .ch_wdata(ch_wdata), .ch_wr(ch_wr), .ch_rd(ch_rd),
        .ch_rdata(ch_rdata)
    );

    // Channel register-bank models
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 8; c++) begin
                for (int o = 0; o < 16; o++) mem[c][o] <= 8'h00;
                tx_last[c] <= 8'h00;
                tx_cnt[c]  <= 0;
            end
            wr_total <= 0;
            rd_total <= 0;
        end else begin
            for (int c = 0; c < 8; c++) begin
                if (ch_wr[c]) begin
                    if (ch_addr == 4'd0) begin
                        tx_last[c] <= ch_wdata;
                        tx_cnt[c]  <= tx_cnt[c] + 1;
                    end else begin
                        mem[c][ch_addr] <= ch_wdata;
                    end
                end
            end
            wr_total <= wr_total + $countones(ch_wr);
            rd_total <= rd_total + $countones(ch_rd);
        end
    end

    always_comb begin
        for (int c = 0; c < 8; c++) begin
            ch_rdata[c*8 +: 8] = (ch_addr == 4'd0) ? 8'(8'h50 + c) : mem[c][ch_addr];
        end
    end

    function automatic logic [7:0] pat(int c, int o);
        return 8'((c * 16 + o) ^ 8'h5A);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        int snap_wr, snap_rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset rdata", bus_rdata, 0);
        chk("R8 reset strobes", {ch_wr, ch_rd}, 0);

        do_read(8'h80, rv); chk("R4 id", rv, 8'h28);
        do_read(8'h81, rv); chk("R5 rev", rv, 8'h01);
        do_read(8'h82, rv); chk("R6 ctl reset", rv, 8'h00);
        @(negedge clk); chk("R9 idle after read", bus_rdata, 0);

        do_write(8'h82, 8'hFF); do_read(8'h82, rv); chk("R6 ctl ones", rv, 8'h01);
        do_write(8'h82, 8'hFE); do_read(8'h82, rv); chk("R6 ctl reserved", rv, 8'h00);
        do_write(8'h82, 8'hAB); do_read(8'h82, rv); chk("R6 ctl odd", rv, 8'h01);
        do_write(8'h82, 8'h00);

        do_write(8'h80, 8'h55); do_write(8'h81, 8'h55);
        do_read(8'h80, rv); chk("R10 id after write", rv, 8'h28);
        do_read(8'h81, rv); chk("R10 rev after write", rv, 8'h01);
        chk("R10 no channel write", wr_total, 0);

        // R1: individual configuration writes, exhaustive over channels and offsets
        for (int c = 0; c < 8; c++)
            for (int o = 1; o < 16; o++)
                do_write(8'(c * 16 + o), pat(c, o));
        @(negedge clk);
        chk("R1 strobe count", wr_total, 120);
        for (int c = 0; c < 8; c++)
            for (int o = 1; o < 16; o++) begin
                do_read(8'(c * 16 + o), rv);
                chk("R1 R3 readback", rv, pat(c, o));
            end
        for (int c = 0; c < 8; c++) begin
            do_read(8'(c * 16), rv);
            chk("R3 receive byte", rv, 8'h50 + c);
        end
        chk("R3 read strobes", rd_total, 128);

        // R2: data-port writes, fan-out off
        for (int c = 0; c < 8; c++) do_write(8'(c * 16), 8'(8'hE0 + c));
        @(negedge clk);
        for (int c = 0; c < 8; c++) begin
            chk("R2 tx byte", tx_last[c], 8'hE0 + c);
            chk("R2 tx count", tx_cnt[c], 1);
        end

        // R7: fan-out on
        do_write(8'h82, 8'h01);
        do_write(8'h53, 8'hC3);
        for (int c = 0; c < 8; c++) begin
            do_read(8'(c * 16 + 3), rv);
            chk("R7 fan-out value", rv, 8'hC3);
            do_read(8'(c * 16 + 4), rv);
            chk("R7 neighbour kept", rv, pat(c, 4));
        end
        do_write(8'h20, 8'h77);
        @(negedge clk);
        for (int c = 0; c < 8; c++)
            chk("R2 data port under fan-out", tx_cnt[c], (c == 2) ? 2 : 1);
        chk("R2 tx byte under fan-out", tx_last[2], 8'h77);

        // R8: global and unmapped sweep
        snap_wr = wr_total; snap_rd = rd_total;
        for (int a = 8'h83; a < 256; a++) do_write(8'(a), 8'hFF);
        for (int a = 8'h83; a < 256; a++) begin
            do_read(8'(a), rv);
            chk("R8 unmapped read", rv, 0);
        end
        @(negedge clk);
        chk("R8 no writes", wr_total, snap_wr);
        chk("R8 no reads", rd_total, snap_rd);
        do_read(8'h82, rv); chk("R8 ctl untouched", rv, 8'h01);

        // Fan-out off again: single channel only
        do_write(8'h82, 8'h00);
        do_write(8'h13, 8'h11);
        do_read(8'h13, rv); chk("R1 single after fan-out off", rv, 8'h11);
        do_read(8'h03, rv); chk("R6 fan-out cleared", rv, 8'hC3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule